// File: doc/BRIEF.md
# Quadrature Mixer Front End

This block is the first stage of a digital down-conversion chain, clocked by the converter sample clock. Each clock it takes one 12-bit offset-binary converter code and turns it into a two's complement sample. A select input can swap that sample for a built-in test tone. The chosen sample is then multiplied by the cosine and the sine of a local oscillator, which gives an in-phase (I) product and a quadrature (Q) product. Both products are registered and share one valid flag.

The local oscillator is a 32-bit phase accumulator. Its top 8 bits address a quarter-wave sine table that is folded by symmetry to cover the full turn. The oscillator frequency comes only from an increment register. That register is reloaded by a small control path: it registers a 16-bit tuning word and writes it into the upper half of the increment whenever the registered word differs from its previous value. A reload never clears the accumulator, so the oscillator phase carries on without a jump. The test tone comes from a second accumulator with a fixed increment, read through its own copy of the sine table.

Top module: `iq_mixer_frontend`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `i_out`, `q_out` and `out_valid` are all zero.
- R2: The converter code is read as offset binary: its most significant bit is inverted. So 0x800 becomes 0, 0x000 becomes -2048 and 0xFFF becomes +2047.
- R3: When `tone_sel` is 0 the converter sample is mixed. When `tone_sel` is 1 the internal test tone is mixed.
- R4: At each clock the selected sample is registered. One clock later `i_out` holds that sample times the oscillator cosine, and `q_out` holds it times the oscillator sine, both as 24-bit signed values.
- R5: At clock edge e the oscillator takes a phase index p from the top 8 bits of its accumulator. Its sine value is within 4 LSB of 2047·sin(2π(p+0.5)/256), and its cosine value is the sine value at index p+64 (mod 256). Both are held from edge e, so the product registered at edge e+1 uses them.
- R6: The tuning word is registered at every edge. If the registered word differs from the one registered at the previous edge, the increment becomes {word, 16'h0000} at the next edge. The accumulator adds the new increment from the edge after that. At each edge the accumulator adds the increment it currently holds.
- R7: While the registered tuning word does not change, the increment keeps its value.
- R8: Loading a new increment does not reset or step the accumulator phase. Only the step per clock changes.
- R9: `out_valid` rises at the second clock edge after reset is released and then stays high. I and Q are always valid in the same cycle.
- R10: The test tone is the sine lookup (same table as R5) of a separate 32-bit accumulator that advances by the fixed parameter `TONE_INC` each clock. The tone sample is registered once before the selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter sample clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_code | input | 12 | Offset-binary converter sample |
| tune_word | input | 16 | Oscillator tuning word, upper half of the phase increment |
| tone_sel | input | 1 | 1 selects the internal test tone as the mixer input |
| i_out | output | 24 | Signed in-phase product |
| q_out | output | 24 | Signed quadrature product |
| out_valid | output | 1 | Products are valid |

## Verification
The properties assume that reset is held for at least one clock edge and that every input is stable around each rising edge. The bench meets both by changing inputs only on falling edges and holding reset for several cycles. The product bound and the zero-sample property rely on the selected sample staying within the 12-bit signed range and the table amplitude staying at or below 2047. Any 12-bit code and any 16-bit tuning word meet this, so the random stimulus draws converter codes and tuning words over their full range. Directed steps add the extreme codes, a zero increment and back-to-back tuning-word changes.

// File: rtl/iqmix_pkg.sv
package iqmix_pkg;

   // Quarter-wave sine entry at the middle of step idx. The rational
   // approximation of sine keeps the table a pure integer computation.
   function automatic int quarter_sine(input int idx, input int lut_bits, input int amp);
      longint d;
      longint n;
      longint y;
      longint num;
      longint den;
      d   = longint'(1) << lut_bits;
      n   = 2 * longint'(idx) + 1;
      y   = n * (d - n);
      num = 16 * y * longint'(amp);
      den = 5 * d * d - 4 * y;
      return int'((num + den / 2) / den);
   endfunction

endpackage

// File: rtl/iqmix_sine_rom.sv
module iqmix_sine_rom #(
   parameter int LUT_BITS = 8,
   parameter int AMP_W    = 12
) (
   input  logic [LUT_BITS-1:0]     phase,
   output logic signed [AMP_W-1:0] value
);
   import iqmix_pkg::*;

   localparam int QW  = LUT_BITS - 2;
   localparam int QN  = 1 << QW;
   localparam int AMP = (1 << (AMP_W - 1)) - 1;

   logic [AMP_W-1:0] tab [QN];

   for (genvar g = 0; g < QN; g++) begin : g_tab
      assign tab[g] = AMP_W'(quarter_sine(g, LUT_BITS, AMP));
   end

   logic [QW-1:0]    idx;
   logic [AMP_W-1:0] mag;

   always_comb begin
      idx   = phase[LUT_BITS-2] ? ~phase[QW-1:0] : phase[QW-1:0];
      mag   = tab[idx];
      value = phase[LUT_BITS-1] ? -$signed(mag) : $signed(mag);
   end

endmodule

// File: rtl/iqmix_phase_osc.sv
module iqmix_phase_osc #(
   parameter int PHASE_W  = 32,
   parameter int LUT_BITS = 8,
   parameter int AMP_W    = 12,
   parameter int NOUT     = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [PHASE_W-1:0]      step,
   output logic signed [AMP_W-1:0] wave_o [NOUT]
);
   localparam int QN = 1 << (LUT_BITS - 2);

   logic [PHASE_W-1:0] acc;
   logic [LUT_BITS-1:0] ph;

   assign ph = acc[PHASE_W-1 -: LUT_BITS];

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc + step;
   end

   // Output k is shifted by k quarter turns: 0 is sine, 1 is cosine.
   for (genvar k = 0; k < NOUT; k++) begin : g_out
      logic [LUT_BITS-1:0]     ph_k;
      logic signed [AMP_W-1:0] val_k;
      assign ph_k = ph + LUT_BITS'(k * QN);
      iqmix_sine_rom #(.LUT_BITS(LUT_BITS), .AMP_W(AMP_W)) u_rom (
         .phase (ph_k),
         .value (val_k)
      );
      always_ff @(posedge clk) begin
         if (rst) wave_o[k] <= '0;
         else     wave_o[k] <= val_k;
      end
   end

endmodule

// File: rtl/iqmix_freq_loader.sv
module iqmix_freq_loader #(
   parameter int DISC_W  = 16,
   parameter int PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [DISC_W-1:0]  word_i,
   output logic [DISC_W-1:0]  word_q,
   output logic               load,
   output logic [PHASE_W-1:0] inc_o
);
   localparam int SHIFT = PHASE_W - DISC_W;

   logic [DISC_W-1:0] word_prev;

   assign load = (word_q != word_prev);

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q    <= '0;
         word_prev <= '0;
         inc_o     <= '0;
      end else begin
         word_q    <= word_i;
         word_prev <= word_q;
         if (load) inc_o <= PHASE_W'(word_q) << SHIFT;
      end
   end

endmodule

// File: rtl/iq_mixer_frontend.sv
module iq_mixer_frontend #(
   parameter int             ADC_W    = 12,
   parameter int             DISC_W   = 16,
   parameter int             PHASE_W  = 32,
   parameter int             LUT_BITS = 8,
   parameter int             AMP_W    = 12,
   parameter longint unsigned TONE_INC = 64'h0123_4567
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [ADC_W-1:0]               adc_code,
   input  logic [DISC_W-1:0]              tune_word,
   input  logic                           tone_sel,
   output logic signed [ADC_W+AMP_W-1:0]  i_out,
   output logic signed [ADC_W+AMP_W-1:0]  q_out,
   output logic                           out_valid
);
   localparam int PROD_W = ADC_W + AMP_W;
   localparam logic [PHASE_W-1:0] TONE_STEP = PHASE_W'(TONE_INC);

   if (PHASE_W <= DISC_W) begin : g_bad_phase
      $error("PHASE_W must exceed DISC_W");
   end
   if (LUT_BITS < 3 || LUT_BITS > 12) begin : g_bad_lut
      $error("LUT_BITS must lie in 3..12");
   end
   if (LUT_BITS > PHASE_W) begin : g_bad_lut_w
      $error("LUT_BITS must not exceed PHASE_W");
   end
   if (ADC_W < 2 || AMP_W < 2) begin : g_bad_w
      $error("sample and amplitude widths must be at least 2");
   end

   // Offset-binary to two's complement.
   logic signed [ADC_W-1:0] adc_s;
   assign adc_s = $signed({~adc_code[ADC_W-1], adc_code[ADC_W-2:0]});

   // Frequency control path.
   logic [DISC_W-1:0]  tune_word_q;
   logic               tune_load;
   logic [PHASE_W-1:0] tune_inc;

   iqmix_freq_loader #(.DISC_W(DISC_W), .PHASE_W(PHASE_W)) u_loader (
      .clk    (clk),
      .rst    (rst),
      .word_i (tune_word),
      .word_q (tune_word_q),
      .load   (tune_load),
      .inc_o  (tune_inc)
   );

   // Local oscillator: index 0 sine, index 1 cosine.
   logic signed [AMP_W-1:0] lo_wave [2];

   iqmix_phase_osc #(.PHASE_W(PHASE_W), .LUT_BITS(LUT_BITS), .AMP_W(AMP_W), .NOUT(2)) u_lo (
      .clk    (clk),
      .rst    (rst),
      .step   (tune_inc),
      .wave_o (lo_wave)
   );

   // Test tone: sine only, fixed step.
   logic signed [AMP_W-1:0] tone_wave [1];

   iqmix_phase_osc #(.PHASE_W(PHASE_W), .LUT_BITS(LUT_BITS), .AMP_W(AMP_W), .NOUT(1)) u_tone (
      .clk    (clk),
      .rst    (rst),
      .step   (TONE_STEP),
      .wave_o (tone_wave)
   );

   // Fit the tone amplitude to the sample width.
   logic signed [ADC_W-1:0] tone_s;
   if (AMP_W >= ADC_W) begin : g_tone_narrow
      logic signed [AMP_W-1:0] tone_sh;
      assign tone_sh = tone_wave[0] >>> (AMP_W - ADC_W);
      assign tone_s  = tone_sh[ADC_W-1:0];
   end else begin : g_tone_wide
      assign tone_s = $signed({tone_wave[0], {(ADC_W - AMP_W){1'b0}}});
   end

   logic signed [ADC_W-1:0]  smp_q;
   logic signed [PROD_W-1:0] i_q;
   logic signed [PROD_W-1:0] q_q;
   logic [1:0]               vld_sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         smp_q  <= '0;
         i_q    <= '0;
         q_q    <= '0;
         vld_sr <= '0;
      end else begin
         smp_q  <= tone_sel ? tone_s : adc_s;
         i_q    <= smp_q * lo_wave[1];
         q_q    <= smp_q * lo_wave[0];
         vld_sr <= {vld_sr[0], 1'b1};
      end
   end

   assign i_out     = i_q;
   assign q_out     = q_q;
   assign out_valid = vld_sr[1];

endmodule

// File: rtl/iq_mixer_frontend_chk.sv
module iq_mixer_frontend_chk #(
   parameter int ADC_W   = 12,
   parameter int DISC_W  = 16,
   parameter int PHASE_W = 32,
   parameter int AMP_W   = 12
) (
   input logic                          clk,
   input logic                          rst,
   input logic [DISC_W-1:0]             tune_word_q,
   input logic                          tune_load,
   input logic [PHASE_W-1:0]            tune_inc,
   input logic signed [ADC_W-1:0]       smp_q,
   input logic signed [ADC_W+AMP_W-1:0] i_out,
   input logic signed [ADC_W+AMP_W-1:0] q_out,
   input logic                          out_valid
);
   localparam int  SHIFT = PHASE_W - DISC_W;
   localparam longint LIM = (longint'(1) << (ADC_W - 1)) * ((longint'(1) << (AMP_W - 1)) - 1);

   // R6: a detected change loads the registered word into the upper bits.
   p_load_value_r6: assert property (@(posedge clk) disable iff (rst)
      tune_load |=> (tune_inc == (PHASE_W'($past(tune_word_q)) << SHIFT)));

   // R7: no change, no reload.
   p_hold_inc_r7: assert property (@(posedge clk) disable iff (rst)
      !tune_load |=> $stable(tune_inc));

   // R9: valid never drops once up.
   p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> out_valid);

   // R1: products stay zero until valid.
   p_quiet_invalid_r1: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (i_out == '0 && q_out == '0));

   // R4: a zero sample gives zero products one clock later.
   p_zero_sample_r4: assert property (@(posedge clk) disable iff (rst)
      (smp_q == '0) |=> (i_out == '0 && q_out == '0));

   // R4: products stay inside the range of sample times amplitude.
   p_prod_bound_r4: assert property (@(posedge clk) disable iff (rst)
      (longint'(i_out) <= LIM && longint'(i_out) >= -LIM &&
       longint'(q_out) <= LIM && longint'(q_out) >= -LIM));

endmodule

bind iq_mixer_frontend iq_mixer_frontend_chk #(
   .ADC_W(ADC_W), .DISC_W(DISC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .tune_word_q (tune_word_q),
   .tune_load   (tune_load),
   .tune_inc    (tune_inc),
   .smp_q       (smp_q),
   .i_out       (i_out),
   .q_out       (q_out),
   .out_valid   (out_valid)
);

// File: tb/iq_mixer_frontend_test.sv
module iq_mixer_frontend_test;
   localparam time CLK_PERIOD = 20ns;
   localparam logic [31:0] TONE_STEP = 32'h0123_4567;
   localparam int TOL = 16500;
   localparam real PI = 3.14159265358979;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [11:0]        adc_code = 12'h800;
   logic [15:0]        tune_word = 16'h0;
   logic               tone_sel = 1'b0;
   logic signed [23:0] i_out;
   logic signed [23:0] q_out;
   logic               out_valid;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   iq_mixer_frontend #(.TONE_INC(64'(TONE_STEP))) uut (
      .clk       (clk),
      .rst       (rst),
      .adc_code  (adc_code),
      .tune_word (tune_word),
      .tone_sel  (tone_sel),
      .i_out     (i_out),
      .q_out     (q_out),
      .out_valid (out_valid)
   );

   // Ideal sine at the middle of step p of 256, full scale 2047.
   function automatic int ref_sin(input logic [7:0] p);
      real r;
      r = 2047.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 256.0);
      return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
   endfunction

   function automatic int fmt(input logic [11:0] c);
      return int'($signed(c ^ 12'h800));
   endfunction

   // Reference model built from the requirement timing.
   logic [15:0] m_wq, m_wp;
   logic [31:0] m_inc, m_acc, m_tacc;
   int m_sin, m_cos, m_tsin, m_smp, m_i, m_q;
   logic m_v1, m_v2;

   always @(posedge clk) begin
      if (rst) begin
         m_wq <= '0; m_wp <= '0; m_inc <= '0; m_acc <= '0; m_tacc <= '0;
         m_sin <= 0; m_cos <= 0; m_tsin <= 0; m_smp <= 0; m_i <= 0; m_q <= 0;
         m_v1 <= 1'b0; m_v2 <= 1'b0;
      end else begin
         m_wq  <= tune_word;
         m_wp  <= m_wq;
         if (m_wq != m_wp) m_inc <= {m_wq, 16'h0000};
         m_acc  <= m_acc + m_inc;
         m_sin  <= ref_sin(m_acc[31:24]);
         m_cos  <= ref_sin(m_acc[31:24] + 8'd64);
         m_tacc <= m_tacc + TONE_STEP;
         m_tsin <= ref_sin(m_tacc[31:24]);
         m_smp  <= tone_sel ? m_tsin : fmt(adc_code);
         m_i    <= m_smp * m_cos;
         m_q    <= m_smp * m_sin;
         m_v1   <= 1'b1;
         m_v2   <= m_v1;
      end
   end

   task automatic check(input string req, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   // Compare against the model at the current falling edge.
   task automatic cmp_model();
      check(cur_req, out_valid == m_v2, int'(out_valid), int'(m_v2));
      check(cur_req, absd(int'(i_out), m_i) <= TOL, int'(i_out), m_i);
      check(cur_req, absd(int'(q_out), m_q) <= TOL, int'(q_out), m_q);
   endtask

   task automatic step_n(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cmp_model();
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      adc_code = 12'hFFF;
      tune_word = 16'h1234;
      // R1: reset state.
      repeat (3) @(negedge clk);
      check("R1", i_out == 0, int'(i_out), 0);
      check("R1", q_out == 0, int'(q_out), 0);
      check("R1", out_valid == 1'b0, int'(out_valid), 0);
      tune_word = 16'h0000;
      rst = 1'b0;
      // R9: valid at the second edge after release.
      @(negedge clk);
      check("R1", out_valid == 1'b0 && i_out == 0, int'(out_valid), 0);
      @(negedge clk);
      check("R9", out_valid == 1'b1, int'(out_valid), 1);
      cmp_model();

      // R2: mid-scale code gives exactly zero products; increment is zero.
      cur_req = "R2";
      adc_code = 12'h800;
      step_n(3);
      check("R2", i_out == 0 && q_out == 0, int'(i_out), 0);
      adc_code = 12'h000;
      step_n(3);
      check("R2", absd(int'(i_out), -2048 * ref_sin(8'd64)) <= TOL, int'(i_out), -2048 * ref_sin(8'd64));
      // R5: full-scale code at phase index 0.
      cur_req = "R5";
      adc_code = 12'hFFF;
      step_n(3);
      check("R5", absd(int'(i_out), 2047 * ref_sin(8'd64)) <= TOL, int'(i_out), 2047 * ref_sin(8'd64));
      check("R5", absd(int'(q_out), 2047 * ref_sin(8'd0)) <= TOL, int'(q_out), 2047 * ref_sin(8'd0));

      // R4/R6: random codes with tuning changes.
      cur_req = "R6";
      for (int n = 0; n < 40; n++) begin
         tune_word = 16'($urandom);
         for (int k = 0; k < 6; k++) begin
            adc_code = 12'($urandom);
            step_n(1);
         end
      end
      cur_req = "R4";
      for (int n = 0; n < 200; n++) begin
         adc_code = 12'($urandom);
         step_n(1);
      end
      // R7: a long stretch with the word held.
      cur_req = "R7";
      tune_word = 16'h0400;
      adc_code = 12'hFFF;
      step_n(300);
      // R8: back-to-back changes, phase must carry on.
      cur_req = "R8";
      for (int n = 0; n < 60; n++) begin
         tune_word = (n % 2 == 0) ? 16'h0100 : 16'hF000;
         adc_code = 12'($urandom);
         step_n(1 + (n % 3));
      end
      // R3/R10: internal tone selected.
      cur_req = "R3";
      tone_sel = 1'b1;
      adc_code = 12'h800;
      step_n(3);
      cur_req = "R10";
      for (int n = 0; n < 300; n++) begin
         if (n % 50 == 0) tune_word = 16'($urandom);
         adc_code = 12'($urandom);
         step_n(1);
      end
      cur_req = "R3";
      tone_sel = 1'b0;
      adc_code = 12'h800;
      step_n(3);
      check("R3", i_out == 0 && q_out == 0, int'(i_out), 0);
      finish_run();
   end

endmodule